// File: doc/BRIEF.md
# Auxiliary-Channel Transaction Retry Controller

This block runs the attempts of a single auxiliary-channel transaction. It does not move the transaction itself. It strobes an external attempt engine and waits for that engine to report an outcome class, a reply code and a returned byte count. From that report it decides one of four things: the transaction succeeded, it failed, it is retried at once, or it is retried after a timed pause. A pulse on `xact_go` starts each new transaction, and a one-cycle `xact_done` ends it with the result on `xact_pass`.

Each kind of failure has its own retry counter and its own limit. Some outcomes clear counters that belong to other causes. An overall cap limits how many attempts one transaction may make. The pause timer counts `CYC_PER_US` clock cycles per microsecond. A pause is only taken after a short read that was acknowledged, or after a malformed reply.

Encodings. The outcome (`try_outcome`) is 0 = channel completed, 1 = malformed reply, 2 = no response in time, 3 = aborted. The reply (`try_reply`) is 0 = ACK, 1 = native NACK, 2 = native DEFER, 3 = bridged-I2C NACK, 4 = bridged-I2C DEFER, 5 = I2C DEFER, 6 = sink unplugged. Codes 7 to 15 are unknown.

Top module: `aux_retry_ctrl`

## Requirements
- R1: A transaction makes at most `ATTEMPT_CAP` attempts (default 7). An attempt that would lead to a retry once that many attempts have been made ends the transaction as failed.
- R2: Outcome 0 with reply 0 passes when the request is a write, or when it is a read whose `try_count` equals the requested length.
- R3: Outcome 0 with reply 0 on a read whose `try_count` differs from the length increments the short-read counter. The transaction fails when that counter reaches `ACK_LIMIT` (default 7). Otherwise there is a pause of `ACK_WAIT_US` (default 300) microseconds and then a retry.
- R4: Outcome 0 with reply 2, 3 or 4 increments one shared deferral counter. The transaction fails when that counter reaches `DEFER_LIMIT` (default 7). Otherwise the next attempt starts with no pause.
- R5: Outcome 0 with reply 5 clears the shared deferral counter and increments a separate I2C-deferral counter. The transaction fails when that counter reaches `I2C_DEFER_LIMIT` (default 7). Otherwise it retries with no pause.
- R6: Outcome 0 with reply 1, reply 6 or any reply from 7 to 15 fails the transaction at once. Outcome 3 also fails it at once.
- R7: Outcome 1 increments the malformed-reply counter. The transaction fails when that counter reaches `INVALID_LIMIT` (default 2). Otherwise there is a pause of `INV_WAIT_US` (default 400) microseconds and then a retry.
- R8: Outcome 2 increments the no-response counter. The transaction fails when that counter reaches `TIMEOUT_LIMIT` (default 3). Otherwise it retries with no pause.
- R9: Every outcome 0 clears both the no-response counter and the malformed-reply counter.
- R10: All retry counters and the attempt count are cleared when a new transaction starts.
- R11: During and after reset, `try_start`, `wait_busy`, `xact_busy`, `xact_done` and `xact_pass` are low.
- R12: `try_start` is a one-cycle pulse. It comes in the cycle after `xact_go` is accepted, in the cycle after an immediate-retry report, or in the cycle after a pause ends. A pause holds `wait_busy` high for exactly microseconds × `CYC_PER_US` cycles. `xact_done` pulses in the cycle after the final report.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| xact_go | input | 1 | Start a transaction; accepted while idle |
| xact_write | input | 1 | Request direction, 1 = write |
| xact_len | input | LEN_W | Requested byte count |
| try_start | output | 1 | Strobe that launches one attempt |
| try_done | input | 1 | Attempt report valid |
| try_outcome | input | 2 | Outcome class of the attempt |
| try_reply | input | 4 | Reply code of the attempt |
| try_count | input | LEN_W | Bytes returned by the attempt |
| wait_busy | output | 1 | Pause timer running |
| xact_busy | output | 1 | Transaction in progress |
| xact_done | output | 1 | One-cycle end-of-transaction pulse |
| xact_pass | output | 1 | Result, valid from `xact_done` until the next start |

## Verification
Several bench cases are built so that a missing counter clear or counter reset changes the result. Deferrals split by an I2C deferral must pass. A design that did not clear the shared counter would fail on the fourth attempt. No-response and malformed reports split by a completed attempt must pass. A design that kept counting across those would stop early. A deferral left over from the previous transaction must not count against the next one. One mixed sequence never reaches a per-cause limit, so only the overall cap can end it. A design that ignored the cap would start an eighth attempt. Pause lengths are checked to the cycle. A controller that paused after a timeout, or that used the wrong wait length, moves every later strobe.

// File: rtl/aux_retry_pkg.sv
package aux_retry_pkg;

    localparam int CTR_W = 8;

    // outcome classes reported by the attempt engine
    localparam logic [1:0] OUT_OK      = 2'd0;
    localparam logic [1:0] OUT_INVALID = 2'd1;
    localparam logic [1:0] OUT_TIMEOUT = 2'd2;
    localparam logic [1:0] OUT_ABORT   = 2'd3;

    // reply codes
    localparam logic [3:0] RPL_ACK       = 4'd0;
    localparam logic [3:0] RPL_NACK      = 4'd1;
    localparam logic [3:0] RPL_DEFER     = 4'd2;
    localparam logic [3:0] RPL_BR_NACK   = 4'd3;
    localparam logic [3:0] RPL_BR_DEFER  = 4'd4;
    localparam logic [3:0] RPL_I2C_DEFER = 4'd5;
    localparam logic [3:0] RPL_UNPLUG    = 4'd6;

    typedef enum logic [1:0] {
        VD_PASS = 2'd0,
        VD_FAIL = 2'd1,
        VD_NOW  = 2'd2,
        VD_WAIT = 2'd3
    } verdict_e;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_LAUNCH = 2'd1,
        ST_AWAIT  = 2'd2,
        ST_PAUSE  = 2'd3
    } ctrl_state_e;

    typedef struct packed {
        logic [CTR_W-1:0] short_rd;
        logic [CTR_W-1:0] dfr;
        logic [CTR_W-1:0] i2c_dfr;
        logic [CTR_W-1:0] bad;
        logic [CTR_W-1:0] tmo;
    } retry_ctrs_t;

    function automatic logic [CTR_W-1:0] bump(input logic [CTR_W-1:0] v);
        return (v == {CTR_W{1'b1}}) ? v : v + 1'b1;
    endfunction

    function automatic logic at_limit(input logic [CTR_W-1:0] v, input int lim);
        return int'(v) >= lim;
    endfunction

endpackage

// File: rtl/aux_retry_judge.sv
module aux_retry_judge
    import aux_retry_pkg::*;
#(
    parameter int LEN_W           = 5,
    parameter int ACK_LIMIT       = 7,
    parameter int DEFER_LIMIT     = 7,
    parameter int I2C_DEFER_LIMIT = 7,
    parameter int INVALID_LIMIT   = 2,
    parameter int TIMEOUT_LIMIT   = 3
) (
    input  logic [1:0]       outcome,
    input  logic [3:0]       reply,
    input  logic [LEN_W-1:0] count,
    input  logic [LEN_W-1:0] req_len,
    input  logic             req_write,
    input  retry_ctrs_t      ctrs,
    output verdict_e         verdict,
    output logic             wait_long,
    output retry_ctrs_t      ctrs_nxt
);

    always_comb begin
        ctrs_nxt  = ctrs;
        verdict   = VD_FAIL;
        wait_long = 1'b0;
        unique case (outcome)
            OUT_OK: begin
                ctrs_nxt.tmo = '0;
                ctrs_nxt.bad = '0;
                if (reply == RPL_ACK) begin
                    if (!req_write && (count != req_len)) begin
                        ctrs_nxt.short_rd = bump(ctrs.short_rd);
                        verdict = at_limit(ctrs_nxt.short_rd, ACK_LIMIT) ? VD_FAIL : VD_WAIT;
                    end else begin
                        verdict = VD_PASS;
                    end
                end else if ((reply == RPL_DEFER) || (reply == RPL_BR_NACK) ||
                             (reply == RPL_BR_DEFER)) begin
                    ctrs_nxt.dfr = bump(ctrs.dfr);
                    verdict = at_limit(ctrs_nxt.dfr, DEFER_LIMIT) ? VD_FAIL : VD_NOW;
                end else if (reply == RPL_I2C_DEFER) begin
                    ctrs_nxt.dfr     = '0;
                    ctrs_nxt.i2c_dfr = bump(ctrs.i2c_dfr);
                    verdict = at_limit(ctrs_nxt.i2c_dfr, I2C_DEFER_LIMIT) ? VD_FAIL : VD_NOW;
                end else begin
                    verdict = VD_FAIL;
                end
            end
            OUT_INVALID: begin
                ctrs_nxt.bad = bump(ctrs.bad);
                wait_long    = 1'b1;
                verdict = at_limit(ctrs_nxt.bad, INVALID_LIMIT) ? VD_FAIL : VD_WAIT;
            end
            OUT_TIMEOUT: begin
                ctrs_nxt.tmo = bump(ctrs.tmo);
                verdict = at_limit(ctrs_nxt.tmo, TIMEOUT_LIMIT) ? VD_FAIL : VD_NOW;
            end
            default: verdict = VD_FAIL;
        endcase
    end

endmodule

// File: rtl/aux_wait_timer.sv
module aux_wait_timer #(
    parameter int CYC_PER_US = 50,
    parameter int US_W       = 9
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            load,
    input  logic [US_W-1:0] load_us,
    output logic            busy,
    output logic            expire
);

    localparam int TW = US_W + $clog2(CYC_PER_US + 1);

    logic [TW-1:0] span;
    logic [TW-1:0] remain;
    logic          running;

    assign span = TW'(load_us) * TW'(CYC_PER_US);

    always_ff @(posedge clk) begin
        if (rst) begin
            running <= 1'b0;
            remain  <= '0;
        end else if (load) begin
            running <= 1'b1;
            remain  <= span - 1'b1;
        end else if (running) begin
            if (remain == '0) begin
                running <= 1'b0;
            end else begin
                remain <= remain - 1'b1;
            end
        end
    end

    assign busy   = running;
    assign expire = running && (remain == '0);

endmodule

// File: rtl/aux_retry_ctrl.sv
module aux_retry_ctrl
    import aux_retry_pkg::*;
#(
    parameter int LEN_W           = 5,
    parameter int CYC_PER_US      = 50,
    parameter int ATTEMPT_CAP     = 7,
    parameter int ACK_LIMIT       = 7,
    parameter int DEFER_LIMIT     = 7,
    parameter int I2C_DEFER_LIMIT = 7,
    parameter int INVALID_LIMIT   = 2,
    parameter int TIMEOUT_LIMIT   = 3,
    parameter int ACK_WAIT_US     = 300,
    parameter int INV_WAIT_US     = 400
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             xact_go,
    input  logic             xact_write,
    input  logic [LEN_W-1:0] xact_len,
    output logic             try_start,
    input  logic             try_done,
    input  logic [1:0]       try_outcome,
    input  logic [3:0]       try_reply,
    input  logic [LEN_W-1:0] try_count,
    output logic             wait_busy,
    output logic             xact_busy,
    output logic             xact_done,
    output logic             xact_pass
);

    localparam int LONGEST = (ACK_WAIT_US > INV_WAIT_US) ? ACK_WAIT_US : INV_WAIT_US;
    localparam int US_W    = $clog2(LONGEST + 1);
    localparam int ATT_W   = $clog2(ATTEMPT_CAP + 1);

    ctrl_state_e       state;
    logic [ATT_W-1:0]  attempts;
    retry_ctrs_t       ctrs;
    retry_ctrs_t       ctrs_nxt;
    logic              hold_write;
    logic [LEN_W-1:0]  hold_len;
    verdict_e          raw_vd;
    verdict_e          final_vd;
    logic              wait_long;
    logic              tmr_load;
    logic              tmr_expire;
    logic              tmr_busy;
    logic [US_W-1:0]   tmr_us;

    aux_retry_judge #(
        .LEN_W           (LEN_W),
        .ACK_LIMIT       (ACK_LIMIT),
        .DEFER_LIMIT     (DEFER_LIMIT),
        .I2C_DEFER_LIMIT (I2C_DEFER_LIMIT),
        .INVALID_LIMIT   (INVALID_LIMIT),
        .TIMEOUT_LIMIT   (TIMEOUT_LIMIT)
    ) judge_i (
        .outcome   (try_outcome),
        .reply     (try_reply),
        .count     (try_count),
        .req_len   (hold_len),
        .req_write (hold_write),
        .ctrs      (ctrs),
        .verdict   (raw_vd),
        .wait_long (wait_long),
        .ctrs_nxt  (ctrs_nxt)
    );

    aux_wait_timer #(
        .CYC_PER_US (CYC_PER_US),
        .US_W       (US_W)
    ) timer_i (
        .clk     (clk),
        .rst     (rst),
        .load    (tmr_load),
        .load_us (tmr_us),
        .busy    (tmr_busy),
        .expire  (tmr_expire)
    );

    // the overall cap overrides any retry verdict
    always_comb begin
        final_vd = raw_vd;
        if (((raw_vd == VD_NOW) || (raw_vd == VD_WAIT)) && (int'(attempts) >= ATTEMPT_CAP)) begin
            final_vd = VD_FAIL;
        end
    end

    assign tmr_load = (state == ST_AWAIT) && try_done && (final_vd == VD_WAIT);
    assign tmr_us   = wait_long ? US_W'(INV_WAIT_US) : US_W'(ACK_WAIT_US);

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= ST_IDLE;
            attempts   <= '0;
            ctrs       <= '0;
            hold_write <= 1'b0;
            hold_len   <= '0;
            xact_done  <= 1'b0;
            xact_pass  <= 1'b0;
        end else begin
            xact_done <= 1'b0;
            unique case (state)
                ST_IDLE: begin
                    if (xact_go) begin
                        hold_write <= xact_write;
                        hold_len   <= xact_len;
                        ctrs       <= '0;
                        attempts   <= '0;
                        xact_pass  <= 1'b0;
                        state      <= ST_LAUNCH;
                    end
                end
                ST_LAUNCH: begin
                    attempts <= attempts + 1'b1;
                    state    <= ST_AWAIT;
                end
                ST_AWAIT: begin
                    if (try_done) begin
                        ctrs <= ctrs_nxt;
                        unique case (final_vd)
                            VD_PASS: begin
                                xact_done <= 1'b1;
                                xact_pass <= 1'b1;
                                state     <= ST_IDLE;
                            end
                            VD_FAIL: begin
                                xact_done <= 1'b1;
                                xact_pass <= 1'b0;
                                state     <= ST_IDLE;
                            end
                            VD_NOW:  state <= ST_LAUNCH;
                            VD_WAIT: state <= ST_PAUSE;
                            default: state <= ST_IDLE;
                        endcase
                    end
                end
                ST_PAUSE: begin
                    if (tmr_expire) begin
                        state <= ST_LAUNCH;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign try_start = (state == ST_LAUNCH);
    assign wait_busy = tmr_busy;
    assign xact_busy = (state != ST_IDLE);

endmodule

// File: rtl/aux_retry_chk.sv
module aux_retry_chk #(
    parameter int ATTEMPT_CAP = 7
) (
    input logic       clk,
    input logic       rst,
    input logic       xact_go,
    input logic       xact_busy,
    input logic       try_start,
    input logic       try_done,
    input logic [1:0] try_outcome,
    input logic [3:0] try_reply,
    input logic       wait_busy,
    input logic       xact_done,
    input logic       xact_pass
);

    int starts_seen;
    logic reporting;

    assign reporting = try_done && xact_busy && !wait_busy && !try_start;

    always_ff @(posedge clk) begin
        if (rst) begin
            starts_seen <= 0;
        end else if (xact_go && !xact_busy) begin
            starts_seen <= 0;
        end else if (try_start) begin
            starts_seen <= starts_seen + 1;
        end
    end

    AST_ATTEMPT_CAP: assert property (@(posedge clk) disable iff (rst)
        starts_seen <= ATTEMPT_CAP); // R1

    AST_PAUSE_QUIET: assert property (@(posedge clk) disable iff (rst)
        wait_busy |-> (!try_start && !xact_done)); // R3

    AST_ABORT_FAILS: assert property (@(posedge clk) disable iff (rst)
        (reporting && try_outcome == 2'd3) |=> (xact_done && !xact_pass)); // R6

    AST_NACK_FAILS: assert property (@(posedge clk) disable iff (rst)
        (reporting && try_outcome == 2'd0 && try_reply == 4'd1) |=> (xact_done && !xact_pass)); // R6

    AST_TIMEOUT_NO_PAUSE: assert property (@(posedge clk) disable iff (rst)
        (reporting && try_outcome == 2'd2) |=> (try_start || xact_done)); // R8

    AST_GO_LAUNCHES: assert property (@(posedge clk) disable iff (rst)
        (xact_go && !xact_busy) |=> try_start); // R12

    AST_START_PULSE: assert property (@(posedge clk) disable iff (rst)
        try_start |=> !try_start); // R12

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
        xact_done |=> !xact_done); // R12

endmodule

bind aux_retry_ctrl aux_retry_chk #(.ATTEMPT_CAP(ATTEMPT_CAP)) chk_i (
    .clk         (clk),
    .rst         (rst),
    .xact_go     (xact_go),
    .xact_busy   (xact_busy),
    .try_start   (try_start),
    .try_done    (try_done),
    .try_outcome (try_outcome),
    .try_reply   (try_reply),
    .wait_busy   (wait_busy),
    .xact_done   (xact_done),
    .xact_pass   (xact_pass)
);

// File: tb/aux_retry_ctrl_tb_top.sv
module aux_retry_ctrl_tb_top;

    localparam int LEN_W   = 5;
    localparam int CPU     = 2;
    localparam int CAP     = 7;
    localparam int ACK_LIM = 3;
    localparam int DFR_LIM = 3;
    localparam int I2C_LIM = 4;
    localparam int INV_LIM = 2;
    localparam int TMO_LIM = 3;
    localparam int ACK_CYC = 300 * CPU;
    localparam int INV_CYC = 400 * CPU;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             xact_go = 1'b0;
    logic             xact_write = 1'b0;
    logic [LEN_W-1:0] xact_len = '0;
    logic             try_start;
    logic             try_done = 1'b0;
    logic [1:0]       try_outcome = '0;
    logic [3:0]       try_reply = '0;
    logic [LEN_W-1:0] try_count = '0;
    logic             wait_busy;
    logic             xact_busy;
    logic             xact_done;
    logic             xact_pass;

    int checks = 0;
    int fails  = 0;

    int sc_o [0:7];
    int sc_r [0:7];
    int sc_c [0:7];
    int sc_n;

    int m_n, m_ack, m_dfr, m_i2c, m_inv, m_tmo;

    always #10 clk = ~clk;

    aux_retry_ctrl #(
        .LEN_W           (LEN_W),
        .CYC_PER_US      (CPU),
        .ATTEMPT_CAP     (CAP),
        .ACK_LIMIT       (ACK_LIM),
        .DEFER_LIMIT     (DFR_LIM),
        .I2C_DEFER_LIMIT (I2C_LIM),
        .INVALID_LIMIT   (INV_LIM),
        .TIMEOUT_LIMIT   (TMO_LIM),
        .ACK_WAIT_US     (300),
        .INV_WAIT_US     (400)
    ) dut_i (
        .clk         (clk),
        .rst         (rst),
        .xact_go     (xact_go),
        .xact_write  (xact_write),
        .xact_len    (xact_len),
        .try_start   (try_start),
        .try_done    (try_done),
        .try_outcome (try_outcome),
        .try_reply   (try_reply),
        .try_count   (try_count),
        .wait_busy   (wait_busy),
        .xact_busy   (xact_busy),
        .xact_done   (xact_done),
        .xact_pass   (xact_pass)
    );

    task automatic chk(input string tag, input string what, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %0b expected %0b at %0t", tag, what, act, exp, $time);
        end
    endtask

    task automatic add(input int o, input int r, input int c);
        sc_o[sc_n] = o;
        sc_r[sc_n] = r;
        sc_c[sc_n] = c;
        sc_n++;
    endtask

    // behavioural reference: 0 pass, 1 fail, 2 retry now, 3 short-read pause, 4 malformed pause
    task automatic model_step(input int o, input int r, input int c, input bit wr,
                              input int len, output int v);
        m_n++;
        if (o == 0) begin
            m_tmo = 0;
            m_inv = 0;
            if (r == 0) begin
                if (!wr && c != len) begin
                    m_ack++;
                    v = (m_ack >= ACK_LIM) ? 1 : 3;
                end else begin
                    v = 0;
                end
            end else if (r >= 2 && r <= 4) begin
                m_dfr++;
                v = (m_dfr >= DFR_LIM) ? 1 : 2;
            end else if (r == 5) begin
                m_dfr = 0;
                m_i2c++;
                v = (m_i2c >= I2C_LIM) ? 1 : 2;
            end else begin
                v = 1;
            end
        end else if (o == 1) begin
            m_inv++;
            v = (m_inv >= INV_LIM) ? 1 : 4;
        end else if (o == 2) begin
            m_tmo++;
            v = (m_tmo >= TMO_LIM) ? 1 : 2;
        end else begin
            v = 1;
        end
        if (v >= 2 && m_n >= CAP) v = 1;
    endtask

    task automatic run_xact(input bit wr, input int len, input bit exp_final, input string tag);
        int it = 0;
        int start_at = 1;
        int done_at = -1;
        int bfrom = -1;
        int bto = -2;
        int stub_at = -1;
        int idx = 0;
        int v = 0;
        bit exp_pass = 1'b0;
        bit fin = 1'b0;
        m_n = 0; m_ack = 0; m_dfr = 0; m_i2c = 0; m_inv = 0; m_tmo = 0;
        @(negedge clk);
        xact_go    = 1'b1;
        xact_write = wr;
        xact_len   = LEN_W'(len);
        while (!fin && it < 6000) begin
            @(negedge clk);
            it++;
            xact_go  = 1'b0;
            try_done = 1'b0;
            chk(tag, "try_start", try_start, it == start_at);
            chk(tag, "wait_busy", wait_busy, (it >= bfrom) && (it <= bto));
            chk(tag, "xact_done", xact_done, it == done_at);
            if (it == done_at) begin
                chk(tag, "xact_pass", xact_pass, exp_pass);
                chk(tag, "xact_busy", xact_busy, 1'b0);
                fin = 1'b1;
            end
            if (try_start) stub_at = it + 2;
            if (!fin && it == stub_at) begin
                if (idx >= sc_n) begin
                    checks++;
                    fails++;
                    $display("FAIL %s extra attempt: actual %0d expected %0d", tag, idx + 1, sc_n);
                    fin = 1'b1;
                end else begin
                    try_done    = 1'b1;
                    try_outcome = 2'(sc_o[idx]);
                    try_reply   = 4'(sc_r[idx]);
                    try_count   = LEN_W'(sc_c[idx]);
                    model_step(sc_o[idx], sc_r[idx], sc_c[idx], wr, len, v);
                    idx++;
                    case (v)
                        0: begin done_at = it + 1; exp_pass = 1'b1; end
                        1: begin done_at = it + 1; exp_pass = 1'b0; end
                        2: start_at = it + 1;
                        3: begin bfrom = it + 1; bto = it + ACK_CYC; start_at = it + ACK_CYC + 1; end
                        default: begin bfrom = it + 1; bto = it + INV_CYC; start_at = it + INV_CYC + 1; end
                    endcase
                end
            end
        end
        checks++;
        if (!fin) begin
            fails++;
            $display("FAIL %s no completion: actual 0 expected 1", tag);
        end
        checks++;
        if (idx != sc_n || exp_pass != exp_final) begin
            fails++;
            $display("FAIL %s script: actual attempts %0d result %0b expected %0d result %0b",
                     tag, idx, exp_pass, sc_n, exp_final);
        end
        sc_n = 0;
        repeat (2) @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual hung expected finished");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        sc_n = 0;
        repeat (3) @(negedge clk);
        chk("R11", "try_start", try_start, 1'b0);
        chk("R11", "wait_busy", wait_busy, 1'b0);
        chk("R11", "xact_busy", xact_busy, 1'b0);
        chk("R11", "xact_done", xact_done, 1'b0);
        chk("R11", "xact_pass", xact_pass, 1'b0);
        rst = 1'b0;
        @(negedge clk);
        chk("R11", "idle busy", xact_busy, 1'b0);

        // R2 write acked
        add(0, 0, 0);
        run_xact(1'b1, 4, 1'b1, "R2 write");
        // R2 read with full count
        add(0, 0, 4);
        run_xact(1'b0, 4, 1'b1, "R2 read");
        // R3 short read then full read, with pause (R12 timing)
        add(0, 0, 2); add(0, 0, 4);
        run_xact(1'b0, 4, 1'b1, "R3 R12 short");
        // R3 short-read limit
        add(0, 0, 1); add(0, 0, 1); add(0, 0, 1);
        run_xact(1'b0, 4, 1'b0, "R3 limit");
        // R4 shared deferral counter across three codes
        add(0, 2, 0); add(0, 3, 0); add(0, 4, 0);
        run_xact(1'b1, 2, 1'b0, "R4 shared");
        // R5 I2C deferral clears the shared counter
        add(0, 2, 0); add(0, 2, 0); add(0, 5, 0); add(0, 2, 0); add(0, 2, 0); add(0, 5, 0); add(0, 0, 0);
        run_xact(1'b1, 2, 1'b1, "R5 clear");
        // R5 I2C deferral limit
        add(0, 5, 0); add(0, 5, 0); add(0, 5, 0); add(0, 5, 0);
        run_xact(1'b1, 2, 1'b0, "R5 limit");
        // R6 immediate failures
        add(0, 1, 0);
        run_xact(1'b1, 2, 1'b0, "R6 nack");
        add(0, 6, 0);
        run_xact(1'b1, 2, 1'b0, "R6 unplug");
        add(0, 11, 0);
        run_xact(1'b0, 2, 1'b0, "R6 unknown");
        add(3, 0, 0);
        run_xact(1'b0, 2, 1'b0, "R6 abort");
        // R7 malformed replies with pause
        add(1, 0, 0); add(1, 0, 0);
        run_xact(1'b0, 2, 1'b0, "R7 limit");
        // R8 timeouts without pause
        add(2, 0, 0); add(2, 0, 0); add(2, 0, 0);
        run_xact(1'b0, 2, 1'b0, "R8 limit");
        // R9 completed outcome clears timeout counter
        add(2, 0, 0); add(2, 0, 0); add(0, 2, 0); add(2, 0, 0); add(2, 0, 0); add(0, 0, 0);
        run_xact(1'b1, 2, 1'b1, "R9 timeout");
        // R9 completed outcome clears malformed counter
        add(1, 0, 0); add(0, 2, 0); add(1, 0, 0); add(0, 0, 0);
        run_xact(1'b1, 2, 1'b1, "R9 malformed");
        // R1 overall cap
        add(2, 0, 0); add(2, 0, 0); add(0, 2, 0); add(2, 0, 0); add(2, 0, 0); add(0, 2, 0); add(2, 0, 0);
        run_xact(1'b1, 2, 1'b0, "R1 cap");
        // R10 counters restart per transaction
        add(0, 2, 0); add(0, 2, 0); add(0, 0, 0);
        run_xact(1'b1, 2, 1'b1, "R10 first");
        add(0, 2, 0); add(0, 0, 0);
        run_xact(1'b1, 2, 1'b1, "R10 second");

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule